// File: doc/BRIEF.md
# Dual-Compare 8-Bit Timer Pair

This block holds two timer channels. Each channel has an up-counter, two compare registers (A and B), a control register, an output-select register and a status register. Each channel counts on a count-enable strobe supplied from outside, and only while its clock-select field is nonzero. Each compare register is checked against the counter every cycle. A newly seen equality sets that register's flag and applies a programmable action to the channel's timer pin. The counter can be cleared by compare match A, by compare match B, or by an external clear input, depending on a clear-select field. When the counter wraps from all ones to zero it sets an overflow flag.

Software reaches the registers over a simple single-cycle register bus with no handshake and no back-pressure. Every access completes in the cycle it is presented, and read data is combinational from the addressed register. A byte access targets one channel. A word access targets the same register in both channels at once, so the pair behaves as 16-bit counter and compare registers. The even channel carries the upper byte. A software flag clear takes two steps: read the flag as 1, then write 0 to it.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, every counter is 0x00, both compare registers of every channel are 0xFF, every timer pin is 0, and every flag is 0.
- R2: When the clock-select field (control bits [2:0]) is nonzero, each cycle with the channel's count strobe high adds 1 to the counter. When the field is 000, the counter holds its value regardless of the strobe.
- R3: An increment from 0xFF to 0x00 sets the overflow flag (status bit 2). A counter cleared to zero by a match clear does not set it.
- R4: The first cycle in which the counter equals compare A (or B) sets flag A (status bit 0) or flag B (status bit 1) on the next clock edge.
- R5: During a cycle in which a compare register is being written, that register's comparison is suppressed. An equality present only in that cycle sets no flag.
- R6: The clear-select field (control bits [4:3]) works as follows. 00 never clears the counter. 01 clears it on match A. 10 clears it on match B. For a match clear, the count strobe that follows the match loads 0x00 instead of incrementing, so the period is the compare value plus 1 strobes.
- R7: With clear-select 11, a high external clear input zeroes the counter on the next clock edge, with or without a strobe. With any other clear-select, the external clear input has no effect.
- R8: Output-select bits [1:0] set the pin action on match A and bits [3:2] set it on match B. The encoding is 00 no change, 01 drive 0, 10 drive 1, 11 toggle. The pin changes on the clock edge after the match is detected.
- R9: When A and B match in the same cycle, only the match B action is applied to the pin.
- R10: A flag is cleared only by writing 0 to its status bit after a read of the status register that returned that bit as 1. Each such read allows one clear. Writing 0 without that read, or writing 1, leaves the flag set.
- R11: If hardware sets a flag in the same cycle that an armed software clear targets it, the flag stays 1.
- R12: Register addresses use bits [2:0]: 0 control, 1 output select, 2 status, 3 counter, 4 compare A, 5 compare B. Addresses 6 and 7 read as zero. In a byte access, address bit 3 selects the channel (0 is the even channel) and data uses bits [7:0].
- R13: In a word access, address bit 3 is ignored. Data bits [15:8] go to or come from the even channel and bits [7:0] go to or come from the odd channel, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_stb_i | input | 2 | Count-enable strobe, one per channel |
| ext_clr_i | input | 2 | External counter clear, one per channel |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (arms flag clearing) |
| bus_word_i | input | 1 | 1 = 16-bit paired access, 0 = byte access |
| bus_addr_i | input | 4 | Register address; bit 3 selects channel for byte access |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational |
| tmo_o | output | 2 | Timer pin, one per channel |
| cmfa_o | output | 2 | Compare-match A flag, one per channel |
| cmfb_o | output | 2 | Compare-match B flag, one per channel |
| ovf_o | output | 2 | Overflow flag, one per channel |

## Verification
The bench targets these cases:
- A counter that reaches a compare value in the same cycle that compare register is being rewritten. A design that ignores the write-cycle suppression would raise the flag anyway.
- A status write that clears a flag in the same cycle hardware raises it again. A design where clear wins would lose a match event.
- A zero written to the status bit without a prior read. A design without the read-arming step would drop the flag.
- Equal compare values with opposite pin actions, which expose a design that lets match A win.
- A match clear at 0xFF, which must not count as an overflow.
- Word accesses, where swapped byte lanes or a channel left out of the write show up directly in byte reads of each channel.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int NCH  = 2;
  localparam int NREG = 6;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_OSEL = 3'd1,
    RA_STAT = 3'd2,
    RA_CNT  = 3'd3,
    RA_CMPA = 3'd4,
    RA_CMPB = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'b00,
    PIN_LOW  = 2'b01,
    PIN_HIGH = 2'b10,
    PIN_FLIP = 2'b11
  } pin_act_e;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_MA   = 2'b01,
    CLR_MB   = 2'b10,
    CLR_EXT  = 2'b11
  } clr_sel_e;
endpackage

// File: rtl/dct_pin.sv
module dct_pin
  import dct_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hit_a,
  input  logic     hit_b,
  input  pin_act_e act_a,
  input  pin_act_e act_b,
  output logic     pin_o
);
  pin_act_e act;
  logic     fire;

  // match B outranks match A (R9)
  always_comb begin
    fire = hit_a | hit_b;
    act  = hit_b ? act_b : act_a;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_o <= 1'b0;
    end else if (fire) begin
      case (act)
        PIN_LOW:  pin_o <= 1'b0;
        PIN_HIGH: pin_o <= 1'b1;
        PIN_FLIP: pin_o <= ~pin_o;
        default:  pin_o <= pin_o;
      endcase
    end
  end
endmodule

// File: rtl/dct_chan.sv
module dct_chan
  import dct_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stb_i,
  input  logic                     ext_clr_i,
  input  logic [NREG-1:0]          we_i,
  input  logic [W-1:0]             wdata_i,
  input  logic                     stat_rd_i,
  output logic [NREG-1:0][W-1:0]   regs_o,
  output logic                     tmo_o,
  output logic                     cmfa_o,
  output logic                     cmfb_o,
  output logic                     ovf_o
);
  localparam logic [W-1:0] CMP_RST = '1;

  logic [W-1:0] cnt, cmpa, cmpb;
  logic [2:0]   cks;
  clr_sel_e     clrsel;
  logic [3:0]   osel;
  logic [2:0]   flag, armed, set_v, clr_v, flag_n, armed_n;
  logic         eqa, eqb, eqa_q, eqb_q, hit_a, hit_b;
  logic         run, clr_now, wrap;

  always_comb begin
    eqa   = (cnt == cmpa) && !we_i[RA_CMPA];
    eqb   = (cnt == cmpb) && !we_i[RA_CMPB];
    hit_a = eqa && !eqa_q;
    hit_b = eqb && !eqb_q;
    run   = stb_i && (cks != 3'd0);
    clr_now = ((clrsel == CLR_EXT) && ext_clr_i) ||
              (run && (clrsel == CLR_MA) && eqa) ||
              (run && (clrsel == CLR_MB) && eqb);
    wrap  = run && !clr_now && !we_i[RA_CNT] && (cnt == '1);
    set_v = {wrap, hit_b, hit_a};
    clr_v = (we_i[RA_STAT] ? ~wdata_i[2:0] : 3'b000) & armed;
    flag_n  = set_v | (flag & ~clr_v);
    armed_n = flag_n & ((armed & ~clr_v) | (stat_rd_i ? flag : 3'b000));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      cmpa  <= CMP_RST;
      cmpb  <= CMP_RST;
      cks   <= 3'd0;
      clrsel <= CLR_NONE;
      osel  <= 4'd0;
      flag  <= 3'b000;
      armed <= 3'b000;
      eqa_q <= 1'b0;
      eqb_q <= 1'b0;
    end else begin
      if (we_i[RA_CNT])      cnt <= wdata_i;
      else if (clr_now)      cnt <= '0;
      else if (run)          cnt <= cnt + 1'b1;
      if (we_i[RA_CMPA])     cmpa <= wdata_i;
      if (we_i[RA_CMPB])     cmpb <= wdata_i;
      if (we_i[RA_CTRL]) begin
        cks    <= wdata_i[2:0];
        clrsel <= clr_sel_e'(wdata_i[4:3]);
      end
      if (we_i[RA_OSEL])     osel <= wdata_i[3:0];
      flag  <= flag_n;
      armed <= armed_n;
      eqa_q <= eqa;
      eqb_q <= eqb;
    end
  end

  always_comb begin
    regs_o          = '0;
    regs_o[RA_CTRL] = W'({clrsel, cks});
    regs_o[RA_OSEL] = W'(osel);
    regs_o[RA_STAT] = W'(flag);
    regs_o[RA_CNT]  = cnt;
    regs_o[RA_CMPA] = cmpa;
    regs_o[RA_CMPB] = cmpb;
  end

  assign cmfa_o = flag[0];
  assign cmfb_o = flag[1];
  assign ovf_o  = flag[2];

  dct_pin u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .hit_a (hit_a),
    .hit_b (hit_b),
    .act_a (pin_act_e'(osel[1:0])),
    .act_b (pin_act_e'(osel[3:2])),
    .pin_o (tmo_o)
  );
endmodule

// File: rtl/dct_busif.sv
module dct_busif
  import dct_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                           bus_wr_i,
  input  logic                           bus_rd_i,
  input  logic                           bus_word_i,
  input  logic [3:0]                     bus_addr_i,
  input  logic [2*W-1:0]                 bus_wdata_i,
  input  logic [NCH-1:0][NREG-1:0][W-1:0] regs_i,
  output logic [NCH-1:0][NREG-1:0]       we_o,
  output logic [NCH-1:0][W-1:0]          wd_o,
  output logic [NCH-1:0]                 stat_rd_o,
  output logic [2*W-1:0]                 rdata_o
);
  logic [2:0]     ra;
  logic           valid;
  logic [NCH-1:0] hit;

  assign ra    = bus_addr_i[2:0];
  assign valid = (ra < 3'(NREG));

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    assign hit[c]       = valid && (bus_word_i || (bus_addr_i[3] == 1'(c)));
    assign we_o[c]      = (bus_wr_i && hit[c]) ? (NREG'(1) << ra) : '0;
    assign wd_o[c]      = bus_word_i ? bus_wdata_i[(NCH-1-c)*W +: W] : bus_wdata_i[W-1:0];
    assign stat_rd_o[c] = bus_rd_i && hit[c] && (ra == RA_STAT);
  end

  always_comb begin
    rdata_o = '0;
    if (valid) begin
      if (bus_word_i) rdata_o = {regs_i[0][ra], regs_i[1][ra]};
      else            rdata_o[W-1:0] = regs_i[bus_addr_i[3]][ra];
    end
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cnt_stb_i,
  input  logic [1:0]     ext_clr_i,
  input  logic           bus_wr_i,
  input  logic           bus_rd_i,
  input  logic           bus_word_i,
  input  logic [3:0]     bus_addr_i,
  input  logic [2*W-1:0] bus_wdata_i,
  output logic [2*W-1:0] bus_rdata_o,
  output logic [1:0]     tmo_o,
  output logic [1:0]     cmfa_o,
  output logic [1:0]     cmfb_o,
  output logic [1:0]     ovf_o
);
  logic [NCH-1:0][NREG-1:0][W-1:0] ch_regs;
  logic [NCH-1:0][NREG-1:0]        ch_we;
  logic [NCH-1:0][W-1:0]           ch_wd;
  logic [NCH-1:0]                  ch_stat_rd;
  logic [NCH-1:0][W-1:0]           ch_cnt, ch_cmpa, ch_cmpb;
  logic [NCH-1:0][2:0]             ch_cks;

  dct_busif #(.W(W)) u_bus (
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_word_i  (bus_word_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .regs_i      (ch_regs),
    .we_o        (ch_we),
    .wd_o        (ch_wd),
    .stat_rd_o   (ch_stat_rd),
    .rdata_o     (bus_rdata_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dct_chan #(.W(W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb_i     (cnt_stb_i[c]),
      .ext_clr_i (ext_clr_i[c]),
      .we_i      (ch_we[c]),
      .wdata_i   (ch_wd[c]),
      .stat_rd_i (ch_stat_rd[c]),
      .regs_o    (ch_regs[c]),
      .tmo_o     (tmo_o[c]),
      .cmfa_o    (cmfa_o[c]),
      .cmfb_o    (cmfb_o[c]),
      .ovf_o     (ovf_o[c])
    );
    assign ch_cnt[c]  = ch_regs[c][RA_CNT];
    assign ch_cmpa[c] = ch_regs[c][RA_CMPA];
    assign ch_cmpb[c] = ch_regs[c][RA_CMPB];
    assign ch_cks[c]  = ch_regs[c][RA_CTRL][2:0];
  end
endmodule

// File: rtl/dct_chk.sv
module dct_chk
  import dct_pkg::*;
#(
  parameter int W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr_i,
  input logic [NCH-1:0]        ext_clr_i,
  input logic [NCH-1:0][W-1:0] cnt,
  input logic [NCH-1:0][W-1:0] cmpa,
  input logic [NCH-1:0][W-1:0] cmpb,
  input logic [NCH-1:0][2:0]   cks,
  input logic [NCH-1:0]        tmo,
  input logic [NCH-1:0]        cmfa,
  input logic [NCH-1:0]        cmfb,
  input logic [NCH-1:0]        ovf
);
  for (genvar c = 0; c < NCH; c++) begin : g_prop
    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cks[c] == 3'd0 && !bus_wr_i && !ext_clr_i[c]) |=> $stable(cnt[c]));

    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr_i && !ext_clr_i[c]) |=>
        ($stable(cnt[c]) || cnt[c] == '0 || cnt[c] == $past(cnt[c]) + W'(1)));

    a_r3_ovf_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[c]) |-> (cnt[c] == '0));

    a_r4_flag_a_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmfa[c]) |-> $past(cnt[c] == cmpa[c]));

    a_r4_flag_b_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmfb[c]) |-> $past(cnt[c] == cmpb[c]));

    a_r8_pin_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tmo[c]) |-> $past(cnt[c] == cmpa[c] || cnt[c] == cmpb[c]));

    a_r10_flag_fall_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cmfa[c]) || $fell(cmfb[c]) || $fell(ovf[c])) |-> $past(bus_wr_i));
  end
endmodule

bind dual_cmp_timer dct_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_i  (bus_wr_i),
  .ext_clr_i (ext_clr_i),
  .cnt       (ch_cnt),
  .cmpa      (ch_cmpa),
  .cmpb      (ch_cmpb),
  .cks       (ch_cks),
  .tmo       (tmo_o),
  .cmfa      (cmfa_o),
  .cmfb      (cmfb_o),
  .ovf       (ovf_o)
);

// File: tb/dual_cmp_timer_tb.sv
`timescale 1ns/1ps
module dual_cmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cnt_stb, ext_clr;
  logic        bus_wr, bus_rd, bus_word;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [1:0]  tmo, cmfa, cmfb, ovf;
  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  dual_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_stb_i(cnt_stb), .ext_clr_i(ext_clr),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_word_i(bus_word),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tmo_o(tmo), .cmfa_o(cmfa), .cmfb_o(cmfb), .ovf_o(ovf)
  );

  localparam logic [2:0] A_CTRL = 3'd0, A_OSEL = 3'd1, A_STAT = 3'd2,
                         A_CNT = 3'd3, A_CMPA = 3'd4, A_CMPB = 3'd5;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cnt_stb = 2'b00; ext_clr = 2'b00;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_word = 1'b0; bus_addr = 4'd0; bus_wdata = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic ch, input logic [2:0] ra, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_word = 1'b0; bus_addr = {ch, ra}; bus_wdata = {8'h00, d};
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_word(input logic [2:0] ra, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_word = 1'b1; bus_addr = {1'b0, ra}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_word = 1'b0;
  endtask

  task automatic rd(input logic word, input logic [3:0] addr, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_word = word; bus_addr = addr;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_word = 1'b0;
  endtask

  task automatic strobe(input int ch, input int n);
    @(negedge clk);
    cnt_stb[ch] = 1'b1;
    repeat (n) @(negedge clk);
    cnt_stb[ch] = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_reset();
    rd(1'b1, {1'b0, A_CNT}, d);  check("R1 counters", d, 16'h0000);
    rd(1'b1, {1'b0, A_CMPA}, d); check("R1 compare A", d, 16'hFFFF);
    rd(1'b1, {1'b0, A_CMPB}, d); check("R1 compare B", d, 16'hFFFF);
    check("R1 pins", tmo, 2'b00);
    check("R1 flags", {cmfa, cmfb, ovf}, 6'd0);
  endtask

  task automatic t_count();
    logic [15:0] d;
    do_reset();
    wr(1'b0, A_CTRL, 8'h01);
    strobe(0, 5);
    rd(1'b0, {1'b0, A_CNT}, d); check("R2 count 5 strobes", d, 16'h0005);
    wr(1'b0, A_CTRL, 8'h00);
    strobe(0, 4);
    rd(1'b0, {1'b0, A_CNT}, d); check("R2 stopped holds", d, 16'h0005);
    rd(1'b0, {1'b1, A_CNT}, d); check("R2 other channel idle", d, 16'h0000);
  endtask

  task automatic t_overflow();
    logic [15:0] d;
    do_reset();
    wr(1'b0, A_CTRL, 8'h01);
    wr(1'b0, A_CNT, 8'hFD);
    strobe(0, 2);
    rd(1'b0, {1'b0, A_CNT}, d); check("R3 at FF", d, 16'h00FF);
    check("R3 no ovf yet", ovf[0], 1'b0);
    strobe(0, 1);
    rd(1'b0, {1'b0, A_CNT}, d); check("R3 wrapped", d, 16'h0000);
    check("R3 ovf set", ovf[0], 1'b1);
    do_reset();
    wr(1'b0, A_CTRL, 8'h09);
    wr(1'b0, A_CNT, 8'hFE);
    strobe(0, 2);
    rd(1'b0, {1'b0, A_CNT}, d); check("R3 match clear at FF", d, 16'h0000);
    check("R3 match clear no ovf", ovf[0], 1'b0);
  endtask

  task automatic t_match_clear();
    logic [15:0] d;
    do_reset();
    wr(1'b0, A_CMPA, 8'h04);
    wr(1'b0, A_CTRL, 8'h09);
    strobe(0, 4);
    @(negedge clk);
    check("R4 flag A on match", cmfa[0], 1'b1);
    check("R4 flag B untouched", cmfb[0], 1'b0);
    strobe(0, 1);
    rd(1'b0, {1'b0, A_CNT}, d); check("R6 match A clear period", d, 16'h0000);
    do_reset();
    wr(1'b0, A_CMPB, 8'h02);
    wr(1'b0, A_CTRL, 8'h11);
    strobe(0, 3);
    rd(1'b0, {1'b0, A_CNT}, d); check("R6 match B clear", d, 16'h0000);
    check("R4 flag B on match", cmfb[0], 1'b1);
    do_reset();
    wr(1'b0, A_CMPA, 8'h03);
    wr(1'b0, A_CTRL, 8'h01);
    strobe(0, 5);
    rd(1'b0, {1'b0, A_CNT}, d); check("R6 select 00 no clear", d, 16'h0005);
  endtask

  task automatic t_ext_clear();
    logic [15:0] d;
    do_reset();
    wr(1'b1, A_CTRL, 8'h19);
    strobe(1, 6);
    @(negedge clk); ext_clr[1] = 1'b1;
    @(negedge clk); ext_clr[1] = 1'b0;
    rd(1'b0, {1'b1, A_CNT}, d); check("R7 external clear", d, 16'h0000);
    wr(1'b1, A_CTRL, 8'h01);
    strobe(1, 3);
    @(negedge clk); ext_clr[1] = 1'b1;
    @(negedge clk); ext_clr[1] = 1'b0;
    rd(1'b0, {1'b1, A_CNT}, d); check("R7 external clear ignored", d, 16'h0003);
  endtask

  task automatic t_pins();
    do_reset();
    wr(1'b0, A_OSEL, 8'h06);
    wr(1'b0, A_CMPA, 8'h02);
    wr(1'b0, A_CMPB, 8'h05);
    wr(1'b0, A_CTRL, 8'h01);
    strobe(0, 2);
    @(negedge clk);
    check("R8 match A drives 1", tmo[0], 1'b1);
    strobe(0, 3);
    @(negedge clk);
    check("R8 match B drives 0", tmo[0], 1'b0);
    do_reset();
    wr(1'b0, A_OSEL, 8'h0C);
    wr(1'b0, A_CMPB, 8'h03);
    wr(1'b0, A_CTRL, 8'h11);
    strobe(0, 3);
    @(negedge clk);
    check("R8 toggle first", tmo[0], 1'b1);
    strobe(0, 4);
    @(negedge clk);
    check("R8 toggle second", tmo[0], 1'b0);
  endtask

  task automatic t_priority();
    do_reset();
    wr(1'b0, A_OSEL, 8'h06);
    wr(1'b0, A_CMPA, 8'h06);
    wr(1'b0, A_CMPB, 8'h06);
    wr(1'b0, A_CTRL, 8'h01);
    strobe(0, 6);
    @(negedge clk);
    check("R9 B low wins", tmo[0], 1'b0);
    do_reset();
    wr(1'b0, A_OSEL, 8'h09);
    wr(1'b0, A_CMPA, 8'h06);
    wr(1'b0, A_CMPB, 8'h06);
    wr(1'b0, A_CTRL, 8'h01);
    strobe(0, 6);
    @(negedge clk);
    check("R9 B high wins", tmo[0], 1'b1);
  endtask

  task automatic t_block();
    logic [15:0] d;
    do_reset();
    wr(1'b0, A_CNT, 8'h05);
    wr(1'b0, A_CMPA, 8'h09);
    wr(1'b0, A_CTRL, 8'h01);
    @(negedge clk); cnt_stb[0] = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk);
    cnt_stb[0] = 1'b0;
    bus_wr = 1'b1; bus_word = 1'b0; bus_addr = {1'b0, A_CMPA}; bus_wdata = 16'h0014;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    check("R5 compare blocked during write", cmfa[0], 1'b0);
    rd(1'b0, {1'b0, A_CNT}, d);  check("R5 counter at 9", d, 16'h0009);
    rd(1'b0, {1'b0, A_CMPA}, d); check("R5 compare updated", d, 16'h0014);
  endtask

  task automatic t_flags();
    logic [15:0] d;
    do_reset();
    wr(1'b0, A_CMPA, 8'h03);
    wr(1'b0, A_CTRL, 8'h01);
    strobe(0, 3);
    wr(1'b0, A_CTRL, 8'h00);
    check("R4 flag A set", cmfa[0], 1'b1);
    wr(1'b0, A_STAT, 8'h00);
    check("R10 clear without read kept", cmfa[0], 1'b1);
    rd(1'b0, {1'b0, A_STAT}, d); check("R10 status read", d, 16'h0001);
    wr(1'b0, A_STAT, 8'h01);
    check("R10 write 1 kept", cmfa[0], 1'b1);
    wr(1'b0, A_STAT, 8'h00);
    check("R10 armed clear", cmfa[0], 1'b0);
    wr(1'b0, A_CMPA, 8'h03);
    @(negedge clk);
    check("R4 rematch after rewrite", cmfa[0], 1'b1);
    rd(1'b0, {1'b0, A_STAT}, d);
    @(negedge clk);
    bus_wr = 1'b1; bus_word = 1'b0; bus_addr = {1'b0, A_CMPA}; bus_wdata = 16'h0003;
    @(negedge clk);
    bus_addr = {1'b0, A_STAT}; bus_wdata = 16'h0000;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R11 set beats clear", cmfa[0], 1'b1);
    wr(1'b0, A_STAT, 8'h00);
    check("R10 one clear per read", cmfa[0], 1'b1);
  endtask

  task automatic t_word();
    logic [15:0] d;
    do_reset();
    wr_word(A_CNT, 16'hA55A);
    rd(1'b0, {1'b0, A_CNT}, d); check("R13 even upper byte", d, 16'h00A5);
    rd(1'b0, {1'b1, A_CNT}, d); check("R13 odd lower byte", d, 16'h005A);
    rd(1'b1, {1'b1, A_CNT}, d); check("R13 word read", d, 16'hA55A);
    wr(1'b1, A_CMPB, 8'h33);
    rd(1'b1, {1'b0, A_CMPB}, d); check("R12 byte write one channel", d, 16'hFF33);
    wr_word(A_CMPA, 16'h1234);
    rd(1'b0, {1'b0, A_CMPA}, d); check("R13 word cmpA even", d, 16'h0012);
    rd(1'b0, {1'b1, A_CMPA}, d); check("R13 word cmpA odd", d, 16'h0034);
    rd(1'b1, 4'h6, d); check("R12 unused address", d, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_count();
    t_overflow();
    t_match_clear();
    t_ext_clear();
    t_pins();
    t_priority();
    t_block();
    t_flags();
    t_word();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule